// File: doc/BRIEF.md
# Connector Pin-Pair Function Multiplexer

This block owns the pads of a 64-pin expansion connector laid out as two rows of 32 pins. Every pair of neighbouring pins in a row is switched, by a 2-bit code, between general-purpose I/O and an external bus function. When a pair is in general-purpose mode, each pin has an output value bit and a direction bit. A serial transmitter can also take over fixed pins while those pins are in general-purpose mode. The block works out the output value and the output enable of every pad from these settings. Any code outside GPIO and bus leaves the pin undriven. Pins wired to power or ground are never driven.

Software reaches six 32-bit registers through a simple synchronous write port and a combinational read port. Each row has a data register, a direction register and a function register. Reading a data register returns the pad levels after a two-flop synchronizer. Writing a data register changes only the bits whose direction is output. Writing `0x55555555` to both function registers hands the whole connector to the bus.

Top module: `conn_pinmux`

## Requirements
- R1: After a synchronous active-high reset, all function, direction and stored output bits are 0, and no pad is driven while the serial enables are low.
- R2: The register addresses are: 0 row A data, 1 row B data, 2 row A direction, 3 row B direction, 4 row A function, 5 row B function. Direction and function registers read back what was written. Addresses 6 and 7 read 0.
- R3: A data register read returns the pad input levels of that row (row A = pad bits 31:0, row B = pad bits 63:32). A change at the pad is seen by a read after two rising clock edges, and not after only one.
- R4: A write to a data register updates the stored output bit only where the direction bit is 1. All other stored bits keep their value.
- R5: On a general-purpose pin with no serial override, the output enable equals the direction bit. The pad value equals the stored bit while the pin is driven. Any pad whose output enable is 0 outputs value 0.
- R6: Function bits [2k+1:2k] of a row control that row's pins 2k and 2k+1 (zero-based). Code 1 is bus mode, in which the pad follows bus_oe and bus_do.
- R7: Codes 2 and 3 are reserved. A pin under either code has its output enable held at 0.
- R8: Serial channel 0 sits on pad 11 and channel 1 on pad 46. An enabled channel drives its pad with ser_tx, enable 1, whatever the direction bit. This happens only while the pin's pair is in general-purpose mode; in bus mode the bus keeps control.
- R9: Power pads (row A bit 31; row B bits 0, 2, 4, 8, 9, 28, 30) are never driven, and their data-read bits are 0.
- R10: With 0x55555555 in both function registers, every non-power pad follows the bus inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| pad_in | input | 64 | Pad input levels |
| pad_out | output | 64 | Pad output values |
| pad_oe | output | 64 | Pad output enables |
| bus_do | input | 64 | Bus function output values |
| bus_oe | input | 64 | Bus function output enables |
| ser_en | input | 2 | Serial channel open flags |
| ser_tx | input | 2 | Serial transmit levels |

## Verification
The serial override and the function register can act on the same pad at once. The bench enables channel 0 on pad 11 while the pin is in general-purpose mode, then rewrites the function register so that pad 11's pair moves to bus mode with the serial still enabled. It also enables channel 1 while row B is entirely in bus mode. In both cases the pad enable must follow bus_oe and not the serial transmitter. A second overlap is a data write combined with a partial direction mask. The stored word is checked through the pads after the direction is later widened.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
    typedef enum logic [1:0] {
        FN_GPIO = 2'd0,
        FN_BUS  = 2'd1,
        FN_RSV2 = 2'd2,
        FN_RSV3 = 2'd3
    } pin_fn_e;
endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        stage1 <= d;
        q      <= stage1;
    end
endmodule

// File: rtl/pinmux_row_regs.sv
module pinmux_row_regs #(
    parameter int ROW_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_data,
    input  logic             we_dir,
    input  logic             we_fn,
    input  logic [ROW_W-1:0] wdata,
    output logic [ROW_W-1:0] out_q,
    output logic [ROW_W-1:0] dir_q,
    output logic [ROW_W-1:0] fn_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '0;
            fn_q  <= '0;
        end else begin
            if (we_data) out_q <= (out_q & ~dir_q) | (wdata & dir_q);
            if (we_dir)  dir_q <= wdata;
            if (we_fn)   fn_q  <= wdata;
        end
    end

    // R4: stored output bits move only where direction was output
    p_data_masked_r4: assert property (@(posedge clk) disable iff (rst)
        ((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0);
endmodule

// File: rtl/pinmux_pad_sel.sv
module pinmux_pad_sel
    import pinmux_pkg::*;
#(
    parameter int PIN_IDX = 0,
    parameter bit IS_PWR  = 1'b0,
    parameter int SER_CH  = 2,
    parameter int SER_PIN [SER_CH] = '{11, 46}
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_fn_e           fn,
    input  logic              dir,
    input  logic              dout,
    input  logic              bus_do,
    input  logic              bus_oe,
    input  logic [SER_CH-1:0] ser_en,
    input  logic [SER_CH-1:0] ser_tx,
    output logic              pad_out,
    output logic              pad_oe
);
    logic ser_hit;
    logic ser_val;
    logic drv;
    logic val;

    always_comb begin
        ser_hit = 1'b0;
        ser_val = 1'b0;
        for (int c = SER_CH - 1; c >= 0; c--) begin
            if (SER_PIN[c] == PIN_IDX && ser_en[c]) begin
                ser_hit = 1'b1;
                ser_val = ser_tx[c];
            end
        end
    end

    always_comb begin
        drv = 1'b0;
        val = 1'b0;
        unique case (fn)
            FN_GPIO: begin
                if (ser_hit) begin
                    drv = 1'b1;
                    val = ser_val;
                end else begin
                    drv = dir;
                    val = dout;
                end
            end
            FN_BUS: begin
                drv = bus_oe;
                val = bus_do;
            end
            FN_RSV2, FN_RSV3: begin
                drv = 1'b0;
                val = 1'b0;
            end
        endcase
        if (IS_PWR) drv = 1'b0;
    end

    assign pad_oe  = drv;
    assign pad_out = drv & val;

    // R7: reserved codes leave the pad undriven
    p_reserved_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (fn == FN_RSV2 || fn == FN_RSV3) |-> !pad_oe);

    if (!IS_PWR) begin : g_bus_chk
        // R6: a bus-mode pad mirrors the bus inputs
        p_bus_follow_r6: assert property (@(posedge clk) disable iff (rst)
            (fn == FN_BUS) |-> (pad_oe == bus_oe && pad_out == (bus_do & bus_oe)));
    end
endmodule

// File: rtl/conn_pinmux.sv
module conn_pinmux
    import pinmux_pkg::*;
#(
    parameter int ROW_W  = 32,
    parameter int N_ROWS = 2,
    parameter int SER_CH = 2,
    parameter int SER_PIN [SER_CH] = '{11, 46},
    parameter logic [ROW_W*N_ROWS-1:0] PWR_MASK = 64'h5000_0315_8000_0000,
    localparam int N_PINS = ROW_W * N_ROWS,
    localparam int ADDR_W = $clog2(3 * N_ROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [ROW_W-1:0]  reg_wdata,
    output logic [ROW_W-1:0]  reg_rdata,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    input  logic [N_PINS-1:0] bus_do,
    input  logic [N_PINS-1:0] bus_oe,
    input  logic [SER_CH-1:0] ser_en,
    input  logic [SER_CH-1:0] ser_tx
);
    logic [ROW_W-1:0]  out_q [N_ROWS];
    logic [ROW_W-1:0]  dir_q [N_ROWS];
    logic [ROW_W-1:0]  fn_q  [N_ROWS];
    logic [N_PINS-1:0] pin_sync;
    pin_fn_e           pin_fn [N_PINS];

    pinmux_sync #(.W(N_PINS)) u_sync (
        .clk (clk),
        .d   (pad_in),
        .q   (pin_sync)
    );

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        pinmux_row_regs #(.ROW_W(ROW_W)) u_regs (
            .clk     (clk),
            .rst     (rst),
            .we_data (reg_we && reg_addr == ADDR_W'(r)),
            .we_dir  (reg_we && reg_addr == ADDR_W'(N_ROWS + r)),
            .we_fn   (reg_we && reg_addr == ADDR_W'(2 * N_ROWS + r)),
            .wdata   (reg_wdata),
            .out_q   (out_q[r]),
            .dir_q   (dir_q[r]),
            .fn_q    (fn_q[r])
        );

        for (genvar i = 0; i < ROW_W; i++) begin : g_pin
            localparam int P = r * ROW_W + i;

            assign pin_fn[P] = pin_fn_e'(fn_q[r][2 * (i / 2) +: 2]);

            pinmux_pad_sel #(
                .PIN_IDX (P),
                .IS_PWR  (PWR_MASK[P]),
                .SER_CH  (SER_CH),
                .SER_PIN (SER_PIN)
            ) u_pad (
                .clk     (clk),
                .rst     (rst),
                .fn      (pin_fn[P]),
                .dir     (dir_q[r][i]),
                .dout    (out_q[r][i]),
                .bus_do  (bus_do[P]),
                .bus_oe  (bus_oe[P]),
                .ser_en  (ser_en),
                .ser_tx  (ser_tx),
                .pad_out (pad_out[P]),
                .pad_oe  (pad_oe[P])
            );
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int r = 0; r < N_ROWS; r++) begin
            if (reg_addr == ADDR_W'(r))
                reg_rdata = pin_sync[r*ROW_W +: ROW_W] & ~PWR_MASK[r*ROW_W +: ROW_W];
            if (reg_addr == ADDR_W'(N_ROWS + r))
                reg_rdata = dir_q[r];
            if (reg_addr == ADDR_W'(2 * N_ROWS + r))
                reg_rdata = fn_q[r];
        end
    end

    // ---------------- assertions ----------------
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)                 warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R3: synchronized levels lag the pads by exactly two edges
    p_sync_lag_r3: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (pin_sync == $past(pad_in, 2)));

    // R9: power pads never get an output enable
    p_power_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & PWR_MASK) == '0);

    // R1: first cycle after reset leaves every pad undriven
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && ser_en == '0) |-> (pad_oe == '0));

    for (genvar c = 0; c < SER_CH; c++) begin : g_ser_chk
        localparam int SP = SER_PIN[c];
        if (!PWR_MASK[SP]) begin : g_live
            // R8: an open serial channel owns its GPIO-mode pad
            p_serial_over_gpio_r8: assert property (@(posedge clk) disable iff (rst)
                (pin_fn[SP] == FN_GPIO && ser_en[c]) |->
                (pad_oe[SP] && pad_out[SP] == ser_tx[c]));
        end
    end
endmodule

// File: tb/test_conn_pinmux.sv
module test_conn_pinmux;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] pad_in = '0;
    logic [63:0] pad_out;
    logic [63:0] pad_oe;
    logic [63:0] bus_do = '0;
    logic [63:0] bus_oe = '0;
    logic [1:0]  ser_en = '0;
    logic [1:0]  ser_tx = '0;

    always #2 clk = ~clk;

    conn_pinmux i_conn_pinmux (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .bus_do    (bus_do),
        .bus_oe    (bus_oe),
        .ser_en    (ser_en),
        .ser_tx    (ser_tx)
    );

    // kind 0: register read at sel, 1: pad_out of row sel, 2: pad_oe of row sel
    typedef struct {
        string       req;
        int          kind;
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t sb[$];
    int    total = 0;
    int    fails = 0;
    bit    done  = 1'b0;

    localparam logic [31:0] LIVE_A = 32'h7FFF_FFFF;
    localparam logic [31:0] LIVE_B = 32'hAFFF_FCEA;

    task automatic wr(input int a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic push_exp(input string req, input int kind, input int sel,
                            input logic [31:0] exp);
        item_t it;
        if (kind == 0) reg_addr = 3'(sel);
        it.req = req; it.kind = kind; it.sel = sel; it.exp = exp;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    // monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = reg_rdata;
                    1:       act = (it.sel != 0) ? pad_out[63:32] : pad_out[31:0];
                    default: act = (it.sel != 0) ? pad_oe[63:32]  : pad_oe[31:0];
                endcase
                total++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d sel=%0d actual=%h expected=%h",
                             it.req, it.kind, it.sel, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        push_exp("R1", 2, 0, 32'h0);
        push_exp("R1", 2, 1, 32'h0);
        push_exp("R1", 0, 4, 32'h0);
        push_exp("R1", 0, 3, 32'h0);
        // R2 unmapped address
        push_exp("R2", 0, 7, 32'h0);

        // R3 synchronizer latency, R9 power bits read 0
        @(posedge clk); #1;
        pad_in = {32'hFFFF_FFFF, 32'h1234_5678};
        @(posedge clk); #1;
        push_exp("R3", 0, 0, 32'h0);
        @(posedge clk); #1;
        push_exp("R3", 0, 0, 32'h1234_5678);
        push_exp("R9", 0, 1, LIVE_B);

        // R4/R5 data write masked by direction
        wr(0, 32'hFFFF_0000);
        push_exp("R5", 2, 0, 32'h0);
        push_exp("R5", 1, 0, 32'h0);
        wr(2, 32'hFFFF_FFFF);
        push_exp("R4", 1, 0, 32'h0);
        push_exp("R9", 2, 0, LIVE_A);
        wr(0, 32'hDEAD_BEEF);
        push_exp("R5", 1, 0, 32'h5EAD_BEEF);
        wr(2, 32'h0000_FFFF);
        wr(0, 32'h1234_5678);
        push_exp("R5", 1, 0, 32'h0000_5678);
        push_exp("R5", 2, 0, 32'h0000_FFFF);
        wr(2, 32'hFFFF_FFFF);
        push_exp("R4", 1, 0, 32'h5EAD_5678);
        push_exp("R2", 0, 2, 32'hFFFF_FFFF);

        // R7 reserved codes on pairs 0 and 1
        wr(4, 32'h0000_000E);
        push_exp("R7", 2, 0, 32'h7FFF_FFF0);
        push_exp("R7", 1, 0, 32'h5EAD_5670);
        // R6 pair 1 (pins 2,3) in bus mode with bus idle
        wr(4, 32'h0000_0004);
        push_exp("R6", 2, 0, 32'h7FFF_FFF3);
        push_exp("R2", 0, 4, 32'h0000_0004);

        // R8 serial override on pad 11
        wr(4, 32'h0);
        ser_en = 2'b01; ser_tx = 2'b01;
        push_exp("R8", 1, 0, 32'h5EAD_5E78);
        push_exp("R8", 2, 0, LIVE_A);
        wr(2, 32'h0);
        push_exp("R8", 2, 0, 32'h0000_0800);
        push_exp("R8", 1, 0, 32'h0000_0800);
        ser_tx = 2'b00;
        push_exp("R8", 1, 0, 32'h0);
        // same pad's pair moved to bus while serial stays open: bus wins
        wr(4, 32'h0000_0400);
        push_exp("R8", 2, 0, 32'h0);
        ser_en = 2'b00;

        // R10 whole connector to bus, R8 channel 1 ignored in bus mode
        bus_do = {32'hCAFE_F00D, 32'h0F0F_0F0F};
        bus_oe = {32'hFFFF_0000, 32'hFFFF_FFFF};
        wr(4, 32'h5555_5555);
        wr(5, 32'h5555_5555);
        push_exp("R10", 2, 0, LIVE_A);
        push_exp("R10", 1, 0, 32'h0F0F_0F0F);
        push_exp("R10", 2, 1, 32'hAFFF_0000);
        push_exp("R10", 1, 1, 32'h8AFE_0000);
        ser_en = 2'b10; ser_tx = 2'b10;
        push_exp("R8", 2, 1, 32'hAFFF_0000);
        ser_en = 2'b00; ser_tx = 2'b00;

        // R9 power pads stay undriven in GPIO output mode
        wr(5, 32'h0);
        wr(3, 32'hFFFF_FFFF);
        wr(1, 32'hFFFF_FFFF);
        push_exp("R9", 2, 1, LIVE_B);
        push_exp("R9", 1, 1, LIVE_B);
        push_exp("R2", 0, 5, 32'h0);

        @(posedge clk); #1;
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule